// File: doc/BRIEF.md
# Matrix keypad row scanner

This block scans a keypad wired as a grid of 4 rows and 3 columns. It drives one row line low at a time and leaves the others high. While a row is low, it reads the column lines. An open key leaves its column high. A closed key in the driven row pulls its column low. When the scanner finds a closed key, it stops walking and holds on that row. It then checks that the same column stays low for a set number of samples. After that it reports a numeric key code, together with a valid strobe that lasts one clock.

The code is the column index plus four times the row index. The codes therefore leave gaps: 3, 7, 11 and 15 are never produced. After a key is reported, the scanner waits for all columns to read high for the same number of samples before it starts walking again. A key held down is therefore reported once. The column inputs are asynchronous to the clock, so they pass through a two-stage synchronizer first.

A sample happens once per row slot. Each row stays driven for `SETTLE_CYC` clocks, and the columns are read in the last clock of that slot. `SETTLE_CYC` must be at least 3, so that the synchronizer has caught up before the read.

Top module: `keypad_scanner`

## Requirements
- R1: While reset is asserted and in the first clock after it, row 0 is the only driven row (`row_n` = 4'b1110), `key_valid` is 0 and `key_code` is 0.
- R2: With no key pressed, exactly one row line is low at any time. The driven row moves 0, 1, 2, 3 and then back to 0, and each row stays driven for `SETTLE_CYC` clocks.
- R3: A key at row r and column c (both counted from 0) is reported as code c + 4*r on the 4-bit `key_code`. Column c is bit c of `col_n`, and row r is bit r of `row_n`. Code values whose low two bits are 3 never occur.
- R4: If more than one column is low in the driven row, the code of the lowest-numbered low column is reported.
- R5: A key is reported only after `DEBOUNCE_SAMPLES` consecutive samples of its row read the same low column. A press that is shorter than this yields no strobe.
- R6: `key_valid` is high for exactly one clock per accepted press, however long the key is held.
- R7: After a report, no new press is reported until every column has read high for `DEBOUNCE_SAMPLES` consecutive samples. A shorter release followed by a new press of the key produces no second strobe.
- R8: `key_code` keeps the last reported value until the next strobe, including after the key is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| row_n | output | 4 | Row drive lines, active low; exactly one is low |
| col_n | input | 3 | Column sense lines, high when no key in the driven row is closed |
| key_code | output | 4 | Code of the last accepted key: column + 4*row |
| key_valid | output | 1 | One-clock strobe when a new key code is accepted |

## Verification
The bench models the key matrix as switches between rows and columns, so the columns respond only when the right row is driven. It presses two keys in one row at once; a design that picked the highest column or merged the columns would report the wrong code. A press that is too short to pass the debounce count, and a release that is too short to re-arm the scanner, must both stay silent. A design that counts raw clocks instead of samples, or that re-arms on the first high reading, would give an extra strobe. A key held for thousands of clocks checks that the scanner does not report the key again on every scan. Watching the row lines over several full passes checks the slot length and the wrap from row 3 back to row 0.

// File: rtl/kp_pkg.sv
package kp_pkg;
  typedef enum logic [1:0] {
    KP_SEEK    = 2'd0,
    KP_CONFIRM = 2'd1,
    KP_HELD    = 2'd2
  } kp_state_e;
endpackage

// File: rtl/kp_sync.sv
module kp_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '1;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '1;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/kp_row_walker.sv
module kp_row_walker #(
  parameter int ROWS       = 4,
  parameter int SETTLE_CYC = 16,
  localparam int ROW_W     = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int SET_W     = $clog2(SETTLE_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic             sample,
  output logic [ROW_W-1:0] row_idx,
  output logic [ROWS-1:0]  row_n
);
  logic [SET_W-1:0] slot_cnt;

  assign sample = (slot_cnt == SET_W'(SETTLE_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_cnt <= '0;
    else if (sample) slot_cnt <= '0;
    else slot_cnt <= slot_cnt + SET_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row_idx <= '0;
    else if (advance) begin
      if (row_idx == ROW_W'(ROWS - 1)) row_idx <= '0;
      else row_idx <= row_idx + ROW_W'(1);
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_n[r] = (row_idx != ROW_W'(r));
  end

  // R2: exactly one row line is low at any time
  a_r2_one_row_low: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~row_n) == 1);

  // R2: the row only moves at the end of a slot
  a_r2_advance_at_slot_end: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> sample);

  // R2: without an advance the row stays put
  a_r2_row_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(row_idx));
endmodule

// File: rtl/kp_detect.sv
module kp_detect
  import kp_pkg::*;
#(
  parameter int ROWS             = 4,
  parameter int COLS             = 3,
  parameter int DEBOUNCE_SAMPLES = 4,
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W  = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int CODE_W = ROW_W + COL_W,
  localparam int DB_W   = $clog2(DEBOUNCE_SAMPLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic [ROW_W-1:0]  row_idx,
  input  logic [COLS-1:0]   col_s,
  output logic              advance,
  output logic [CODE_W-1:0] key_code,
  output logic              key_valid
);
  // lowest column index whose line reads low
  function automatic logic [COL_W-1:0] lowest_low(input logic [COLS-1:0] c);
    logic [COL_W-1:0] r;
    r = '0;
    for (int i = COLS - 1; i >= 0; i--) begin
      if (!c[i]) r = COL_W'(i);
    end
    return r;
  endfunction

  // code = column + (2**COL_W) * row
  function automatic logic [CODE_W-1:0] code_of(input logic [ROW_W-1:0] r,
                                                 input logic [COL_W-1:0] c);
    return CODE_W'(c) + (CODE_W'(r) << COL_W);
  endfunction

  kp_state_e         state;
  logic [COL_W-1:0]  cand;
  logic [DB_W-1:0]   match_cnt;
  logic [DB_W-1:0]   rel_cnt;
  logic              any_low;
  logic [COL_W-1:0]  low_idx;
  logic              accept;
  logic              release_done;
  logic [COLS-1:0]   low_mask;

  assign any_low  = ~&col_s;
  assign low_idx  = lowest_low(col_s);
  assign low_mask = (COLS'(1) << low_idx) - COLS'(1);

  assign accept = sample && any_low &&
                  (((state == KP_SEEK) && (DEBOUNCE_SAMPLES == 1)) ||
                   ((state == KP_CONFIRM) && (low_idx == cand) &&
                    (match_cnt == DB_W'(DEBOUNCE_SAMPLES - 1))));

  assign release_done = sample && (state == KP_HELD) && !any_low &&
                        (rel_cnt == DB_W'(DEBOUNCE_SAMPLES - 1));

  always_comb begin
    advance = 1'b0;
    if (sample) begin
      unique case (state)
        KP_SEEK, KP_CONFIRM: advance = !any_low;
        KP_HELD:             advance = release_done;
        default:             advance = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= KP_SEEK;
      cand      <= '0;
      match_cnt <= '0;
      rel_cnt   <= '0;
      key_code  <= '0;
      key_valid <= 1'b0;
    end else begin
      key_valid <= 1'b0;
      if (accept) begin
        key_valid <= 1'b1;
        key_code  <= code_of(row_idx, low_idx);
        state     <= KP_HELD;
        rel_cnt   <= '0;
      end else if (sample) begin
        unique case (state)
          KP_SEEK: begin
            if (any_low) begin
              cand      <= low_idx;
              match_cnt <= DB_W'(1);
              state     <= KP_CONFIRM;
            end
          end
          KP_CONFIRM: begin
            if (!any_low) state <= KP_SEEK;
            else if (low_idx != cand) begin
              cand      <= low_idx;
              match_cnt <= DB_W'(1);
            end else match_cnt <= match_cnt + DB_W'(1);
          end
          KP_HELD: begin
            if (any_low) rel_cnt <= '0;
            else if (release_done) state <= KP_SEEK;
            else rel_cnt <= rel_cnt + DB_W'(1);
          end
          default: state <= KP_SEEK;
        endcase
      end
    end
  end

  // R6: the strobe never lasts two clocks
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> !key_valid);

  // R8: the code only changes together with a strobe
  a_r8_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !key_valid |-> $stable(key_code));

  // R3: the column part of a code never exceeds the matrix width
  a_r3_no_gap_code: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> (key_code[COL_W-1:0] < COL_W'(COLS)));

  // R4: the chosen column is low and every lower column is high
  a_r4_lowest_column: assert property (@(posedge clk) disable iff (!rst_n)
    any_low |-> (!col_s[low_idx] && ((col_s & low_mask) == low_mask)));

  // R7: no strobe while waiting for a full release
  a_r7_no_report_held: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == KP_HELD) && $past(state == KP_HELD)) |-> !key_valid);

  // R2: the row is held while a key is being confirmed or held
  a_r5_hold_row_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && any_low) |-> !advance);
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner #(
  parameter int ROWS             = 4,
  parameter int COLS             = 3,
  parameter int SETTLE_CYC       = 16,
  parameter int DEBOUNCE_SAMPLES = 4,
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W  = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int CODE_W = ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ROWS-1:0]   row_n,
  input  logic [COLS-1:0]   col_n,
  output logic [CODE_W-1:0] key_code,
  output logic              key_valid
);
  logic [COLS-1:0]  col_s;
  logic             sample;
  logic             advance;
  logic [ROW_W-1:0] row_idx;

  kp_sync #(.WIDTH(COLS), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (col_n),
    .q     (col_s)
  );

  kp_row_walker #(.ROWS(ROWS), .SETTLE_CYC(SETTLE_CYC)) u_walk (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (advance),
    .sample  (sample),
    .row_idx (row_idx),
    .row_n   (row_n)
  );

  kp_detect #(.ROWS(ROWS), .COLS(COLS), .DEBOUNCE_SAMPLES(DEBOUNCE_SAMPLES)) u_det (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample    (sample),
    .row_idx   (row_idx),
    .col_s     (col_s),
    .advance   (advance),
    .key_code  (key_code),
    .key_valid (key_valid)
  );

  initial begin
    a_r2_settle_min: assert (SETTLE_CYC >= 3);
  end
endmodule

// File: tb/tb_keypad_scanner.sv
module tb_keypad_scanner;
  localparam int SET = 4;
  localparam int DEB = 3;
  localparam int NV  = 9;

  // key mask bit index = row*3 + col
  localparam logic [11:0] VEC_KEYS [NV] = '{
    12'h001, 12'h004, 12'h008, 12'h010, 12'h100,
    12'h200, 12'h800, 12'h180, 12'h006 };
  localparam logic [3:0] VEC_CODE [NV] = '{
    4'd0, 4'd2, 4'd4, 4'd5, 4'd10, 4'd12, 4'd14, 4'd9, 4'd1 };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] row_n;
  logic [2:0] col_n;
  logic [3:0] key_code;
  logic       key_valid;
  logic [11:0] keys = '0;

  int errors = 0, checks = 0;
  int pulses = 0, gap_err = 0, wide_err = 0;
  logic [3:0] last_code = '0;
  logic prev_valid = 1'b0;

  always #10 clk = ~clk;

  always_comb begin
    for (int c = 0; c < 3; c++) begin
      col_n[c] = 1'b1;
      for (int r = 0; r < 4; r++)
        if (keys[r*3+c] && !row_n[r]) col_n[c] = 1'b0;
    end
  end

  keypad_scanner #(.SETTLE_CYC(SET), .DEBOUNCE_SAMPLES(DEB)) dut (
    .clk(clk), .rst_n(rst_n), .row_n(row_n), .col_n(col_n),
    .key_code(key_code), .key_valid(key_valid));

  always @(negedge clk) begin
    if (rst_n) begin
      if (key_valid) begin
        pulses++;
        last_code <= key_code;
        if (key_code[1:0] == 2'd3) gap_err++;
        if (prev_valid) wide_err++;
      end
      prev_valid <= key_valid;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    tick(150000);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [3:0] prev_row;
    int run, changes, bad;
    // R1 reset state
    tick(3);
    check(row_n == 4'b1110, "R1 row_n in reset", row_n, 4'b1110);
    check(key_valid == 1'b0, "R1 key_valid in reset", key_valid, 0);
    rst_n = 1'b1;
    tick(1);
    check(key_code == 4'd0, "R1 key_code after reset", key_code, 0);

    // R2 row walk with no keys
    prev_row = row_n; run = 1; changes = 0; bad = 0;
    for (int i = 0; i < 12*SET; i++) begin
      tick(1);
      if (!(row_n inside {4'b1110, 4'b1101, 4'b1011, 4'b0111})) bad++;
      if (row_n != prev_row) begin
        if (row_n != {prev_row[2:0], prev_row[3]}) bad++;
        if (changes > 0 && run != SET) bad++;
        changes++; run = 1;
      end else run++;
      prev_row = row_n;
    end
    check(bad == 0, "R2 row order and slot length", bad, 0);
    check(changes >= 10, "R2 rows keep walking", changes, 10);

    // R3/R4/R6 table walk
    for (int v = 0; v < NV; v++) begin
      pulses = 0;
      keys = VEC_KEYS[v];
      tick(200);
      check(pulses == 1, "R6 one strobe per press", pulses, 1);
      check(last_code == VEC_CODE[v], "R3/R4 key code", last_code, VEC_CODE[v]);
      keys = '0;
      tick(100);
      check(pulses == 1, "R7 no strobe on release", pulses, 1);
    end

    // R5 press shorter than the debounce window
    pulses = 0;
    keys = 12'h010; tick(6); keys = '0; tick(150);
    check(pulses == 0, "R5 short press ignored", pulses, 0);

    // R6 long hold
    pulses = 0;
    keys = 12'h010; tick(2000); keys = '0; tick(100);
    check(pulses == 1, "R6 long hold single strobe", pulses, 1);

    // R8 code holds after release
    bad = 0;
    for (int i = 0; i < 50; i++) begin
      tick(1);
      if (key_code != 4'd5) bad++;
    end
    check(bad == 0, "R8 code held after release", key_code, 5);

    // R7 short release does not re-arm
    pulses = 0;
    keys = 12'h020; tick(200);
    keys = '0; tick(5);
    keys = 12'h020; tick(200);
    keys = '0; tick(100);
    check(pulses == 1, "R7 short release ignored", pulses, 1);
    keys = 12'h020; tick(200); keys = '0; tick(100);
    check(pulses == 2, "R7 full release re-arms", pulses, 2);
    check(last_code == 4'd6, "R3 code row1 col2", last_code, 6);

    check(gap_err == 0, "R3 gap codes never produced", gap_err, 0);
    check(wide_err == 0, "R6 strobe one clock wide", wide_err, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule